// File: doc/BRIEF.md
# Operating-System Tick Timer with Match Channels and Watchdog

This block is a free-running 32-bit up-counter with four compare channels, meant to provide the periodic and one-shot time events an operating system kernel needs. The counter advances by one on every clock cycle in which `tick_en` is high. The clock divider that produces `tick_en` sits outside the block. Each channel holds a 32-bit compare value. When the counter arrives at that value, the channel can latch a pending flag and drive its own interrupt line, provided its enable bit is set.

Software reaches the block through a simple word-addressed register port. Read data is combinational in the same cycle as the request, and writes take effect at the next clock edge. Pending flags are cleared by writing ones. Only flags that are actually pending are affected.

Channel 3 doubles as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block emits a one-cycle reset request and disarms itself. Software must re-arm the watchdog for another shot, and in normal use it keeps pushing the channel 3 compare value ahead of the counter.

Top module: `ostimer_wdt`

## Requirements
- R1: After reset the counter, all four compare values, the pending flags, the interrupt enable register, the watchdog register, every `irq` bit and `rst_req` read as zero.
- R2: The counter increases by exactly one at each clock edge where `tick_en` is high, and holds its value when `tick_en` is low.
- R3: A bus write to the counter loads the written value, and counting continues upward from it. A counter write takes priority over a tick in the same cycle.
- R4: A channel matches when a tick brings the counter to a value equal to that channel's compare value. The comparison is modulo 2^32, so a compare value below the current count is reached after wraparound. Each arrival yields exactly one event, one clock after the counter takes the value, and a counter that then stops does not produce more events.
- R5: On a match, pending flag i (status bits 3:0, bit i for channel i) and `irq[i]` are set only if interrupt enable bit i is set at that moment. A match with the enable bit clear leaves no trace, even if the bit is enabled afterwards.
- R6: Writing the status register clears exactly the bits that are 1 in both the written value and the pending flags. Writing 1 to a flag that is not pending has no effect. Each cleared channel drops its `irq` line, and pending flags stay set until cleared.
- R7: The interrupt enable register keeps only bits 11:0 of a write; bits 31:12 read back as zero.
- R8: When channel 3 matches while watchdog register bit 0 is 1, `rst_req` is high for exactly one cycle and the watchdog register becomes zero. This happens regardless of the interrupt enable bits. With bit 0 clear, no request is made and the register is unchanged.
- R9: A read of an offset outside the map, or of an address not aligned to a word, returns zero and raises `bus_err` in the same cycle. Reads of mapped offsets leave `bus_err` low.
- R10: The byte offsets are fixed as follows:
  - compare values of channels 0 to 3 at 0x00, 0x04, 0x08 and 0x0C;
  - counter at 0x10;
  - pending status at 0x14;
  - watchdog register at 0x18;
  - interrupt enable at 0x1C.

  Each register reads back the last value written to it (R7 masking aside).
- R11: Loading the counter with a value equal to a compare value does not by itself produce a match event; only a tick does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one step per high cycle |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Read of an unmapped or misaligned offset |
| irq | output | 4 | Per-channel interrupt lines, high while the flag is pending |
| rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The bench places compare values just ahead of the counter, just across the 0xFFFFFFFF-to-zero wrap, and at the counter's current value after a direct load. This catches a magnitude compare (firing early or not at all across the wrap), a compare that fires on loads, and a level-sensitive compare that re-fires while the counter is parked. It also checks the case where a match arrives with the enable clear and the enable is set afterwards: a design that latched raw matches would show a stale pending flag. Clear writes carry ones for flags that are not pending, which exposes a plain overwrite or toggle of the status register. The watchdog tests measure the reset request's width, confirm that the block disarms itself, and confirm that a write with a clear arm bit does nothing. A level output or a watchdog that fires repeatedly would show up as extra pulses.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_CH   = 4;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int IEN_W    = 12;
  localparam int WDOG_CH  = 3;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_WDOG   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h1C;
  localparam logic [ADDR_W-1:0] MATCH_END  = ADDR_W'(NUM_CH * 4);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STATUS,
    SEL_WDOG,
    SEL_IEN
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e              kind;
    logic [CH_IDX_W-1:0]   ch;
  } reg_hit_t;

  // Map a byte offset onto a register class and channel index.
  function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] addr);
    reg_hit_t r;
    r.kind = SEL_NONE;
    r.ch   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < MATCH_END) begin
        r.kind = SEL_MATCH;
        r.ch   = addr[CH_IDX_W+1:2];
      end else if (addr == OFS_COUNT) begin
        r.kind = SEL_COUNT;
      end else if (addr == OFS_STATUS) begin
        r.kind = SEL_STATUS;
      end else if (addr == OFS_WDOG) begin
        r.kind = SEL_WDOG;
      end else if (addr == OFS_IEN) begin
        r.kind = SEL_IEN;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ostimer_counter.sv
module ostimer_counter #(
  parameter int W = ostimer_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         adv
);

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c);
    return c + W'(1);
  endfunction

  // adv marks the cycle in which cnt holds a value reached by a tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      adv <= 1'b0;
    end else begin
      adv <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (tick_en) begin
        cnt <= next_count(cnt);
        adv <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ostimer_chan.sv
module ostimer_chan #(
  parameter int W = ostimer_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic         adv,
  output logic [W-1:0] match_val,
  output logic         hit
);

  function automatic logic is_hit(input logic a, input logic [W-1:0] c,
                                  input logic [W-1:0] m);
    return a && (c == m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_val <= '0;
    end else if (wr) begin
      match_val <= wdata;
    end
  end

  assign hit = is_hit(adv, cnt, match_val);

endmodule

// File: rtl/ostimer_status.sv
module ostimer_status #(
  parameter int N = ostimer_pkg::NUM_CH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] ien,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] sts
);

  function automatic logic [N-1:0] clear_mask(input logic [N-1:0] w,
                                              input logic [N-1:0] s);
    return w & s;
  endfunction

  function automatic logic [N-1:0] next_status(input logic [N-1:0] s,
                                               input logic [N-1:0] clr,
                                               input logic [N-1:0] set);
    return (s & ~clr) | set;
  endfunction

  logic [N-1:0] clr_bits;
  logic [N-1:0] set_bits;

  assign clr_bits = clr_wr ? clear_mask(clr_data, sts) : '0;
  assign set_bits = hit & ien;

  // A new event in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
    end else begin
      sts <= next_status(sts, clr_bits, set_bits);
    end
  end

endmodule

// File: rtl/ostimer_wdog.sv
module ostimer_wdog #(
  parameter int W       = ostimer_pkg::DATA_W,
  parameter int ARM_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         trig,
  output logic [W-1:0] wde,
  output logic         rst_req
);

  logic fire;
  assign fire = trig && wde[ARM_BIT];

  // Firing disarms and wins over a write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wde     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire;
      if (fire) begin
        wde <= '0;
      end else if (wr) begin
        wde <= wdata;
      end
    end
  end

endmodule

// File: rtl/ostimer_wdt.sv
module ostimer_wdt
  import ostimer_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NCH  = NUM_CH,
  parameter int IENW = IEN_W,
  parameter int WCH  = WDOG_CH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_err,
  output logic [NCH-1:0] irq,
  output logic           rst_req
);

  reg_hit_t dec;
  logic     wr_en;
  logic     rd_en;

  assign dec   = decode_addr(bus_addr);
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  // Named internal events (also observed by the bound checker).
  logic            cnt_load;
  logic [DW-1:0]   cnt_q;
  logic            cnt_adv;
  logic [NCH-1:0]  chan_hit;
  logic [NCH-1:0]  sts_q;
  logic [IENW-1:0] ien_q;
  logic [DW-1:0]   wde_q;
  logic [DW-1:0]   match_val [NCH];

  assign cnt_load = wr_en && (dec.kind == SEL_COUNT);

  ostimer_counter #(.W(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (cnt_load),
    .load_val (bus_wdata),
    .cnt      (cnt_q),
    .adv      (cnt_adv)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic ch_wr;
    assign ch_wr = wr_en && (dec.kind == SEL_MATCH) &&
                   (dec.ch == CH_IDX_W'(g));
    ostimer_chan #(.W(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ch_wr),
      .wdata     (bus_wdata),
      .cnt       (cnt_q),
      .adv       (cnt_adv),
      .match_val (match_val[g]),
      .hit       (chan_hit[g])
    );
  end

  ostimer_status #(.N(NCH)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (chan_hit),
    .ien      (ien_q[NCH-1:0]),
    .clr_wr   (wr_en && (dec.kind == SEL_STATUS)),
    .clr_data (bus_wdata[NCH-1:0]),
    .sts      (sts_q)
  );

  ostimer_wdog #(.W(DW), .ARM_BIT(0)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_en && (dec.kind == SEL_WDOG)),
    .wdata   (bus_wdata),
    .trig    (chan_hit[WCH]),
    .wde     (wde_q),
    .rst_req (rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (wr_en && (dec.kind == SEL_IEN)) begin
      ien_q <= bus_wdata[IENW-1:0];
    end
  end

  assign irq = sts_q;

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    unique case (dec.kind)
      SEL_MATCH:  rd_val = match_val[dec.ch];
      SEL_COUNT:  rd_val = cnt_q;
      SEL_STATUS: rd_val = DW'(sts_q);
      SEL_WDOG:   rd_val = wde_q;
      SEL_IEN:    rd_val = DW'(ien_q);
      default:    rd_val = '0;
    endcase
  end

  assign bus_rdata = rd_en ? rd_val : '0;
  assign bus_err   = rd_en && (dec.kind == SEL_NONE);

endmodule

// File: rtl/ostimer_wdt_chk.sv
module ostimer_wdt_chk #(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int NCH  = 4,
  parameter int IENW = 12,
  parameter int WCH  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic           bus_err,
  input logic [DW-1:0]  cnt_q,
  input logic           cnt_load,
  input logic [NCH-1:0] chan_hit,
  input logic [NCH-1:0] sts_q,
  input logic [NCH-1:0] ien_lo,
  input logic [DW-1:0]  wde_q,
  input logic           rst_req
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_load) |=> (cnt_q == DW'($past(cnt_q) + 1'b1))); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_load) |=> $stable(cnt_q)); // R2

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (cnt_q == $past(bus_wdata))); // R3

  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_hit != '0) |=> ((chan_hit & $past(chan_hit)) == '0)); // R4

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(ien_lo)) == '0)); // R5

  AST_IEN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(8'h1C))
      |-> (bus_rdata[DW-1:IENW] == '0)); // R7

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8

  AST_RST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (wde_q == '0)); // R8

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(chan_hit[WCH])); // R8

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0)); // R9

endmodule

bind ostimer_wdt ostimer_wdt_chk #(
  .DW(DW), .AW(AW), .NCH(NCH), .IENW(IENW), .WCH(WCH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .cnt_q     (cnt_q),
  .cnt_load  (cnt_load),
  .chan_hit  (chan_hit),
  .sts_q     (sts_q),
  .ien_lo    (ien_q[NCH-1:0]),
  .wde_q     (wde_q),
  .rst_req   (rst_req)
);

// File: tb/ostimer_wdt_bench.sv
module ostimer_wdt_bench;

  localparam logic [7:0] A_M0  = 8'h00;
  localparam logic [7:0] A_M1  = 8'h04;
  localparam logic [7:0] A_M2  = 8'h08;
  localparam logic [7:0] A_M3  = 8'h0C;
  localparam logic [7:0] A_CNT = 8'h10;
  localparam logic [7:0] A_STS = 8'h14;
  localparam logic [7:0] A_WDG = 8'h18;
  localparam logic [7:0] A_IEN = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  irq;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ostimer_wdt u_ostimer_wdt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req) pulses++;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d,
                    output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a,
                          input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    check(tag, d, exp);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    rd_check("R1 counter", A_CNT, 32'h0);
    for (int i = 0; i < 4; i++) rd_check("R1 match", 8'(i * 4), 32'h0);
    rd_check("R1 status", A_STS, 32'h0);
    rd_check("R1 ien", A_IEN, 32'h0);
    rd_check("R1 wdog", A_WDG, 32'h0);
    check("R1 irq", {28'h0, irq}, 32'h0);
    check("R1 rst_req", {31'h0, rst_req}, 32'h0);
  endtask

  task automatic t_count;
    tick(5);
    rd_check("R2 after 5 ticks", A_CNT, 32'd5);
    idle(3);
    rd_check("R2 hold without tick", A_CNT, 32'd5);
  endtask

  task automatic t_load;
    wr(A_CNT, 32'd100);
    tick(3);
    rd_check("R3 load then count", A_CNT, 32'd103);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1;
    bus_addr = A_CNT; bus_wdata = 32'h50;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd_check("R3 write beats tick", A_CNT, 32'h50);
  endtask

  task automatic t_match_enabled;
    wr(A_STS, 32'hF);
    wr(A_IEN, 32'h1);
    wr(A_M0, 32'h200);
    wr(A_CNT, 32'h1FE);
    tick(1); idle(1);
    rd_check("R4 no event before match", A_STS, 32'h0);
    tick(1); idle(1);
    rd_check("R4 status on match", A_STS, 32'h1);
    check("R5 irq0 set", {28'h0, irq}, 32'h1);
    wr(A_STS, 32'h1);
    rd_check("R6 cleared", A_STS, 32'h0);
    check("R6 irq0 dropped", {28'h0, irq}, 32'h0);
    idle(3);
    rd_check("R4 parked counter gives no new event", A_STS, 32'h0);
  endtask

  task automatic t_match_disabled;
    wr(A_IEN, 32'h0);
    wr(A_M1, 32'h300);
    wr(A_CNT, 32'h2FF);
    tick(1); idle(1);
    rd_check("R5 no record when disabled", A_STS, 32'h0);
    check("R5 no irq when disabled", {28'h0, irq}, 32'h0);
    wr(A_IEN, 32'h2);
    idle(2);
    rd_check("R5 late enable shows nothing", A_STS, 32'h0);
  endtask

  task automatic t_clear_mask;
    wr(A_IEN, 32'h3);
    wr(A_M0, 32'h400);
    wr(A_M1, 32'h400);
    wr(A_CNT, 32'h3FF);
    tick(1); idle(1);
    rd_check("R4 two channels same value", A_STS, 32'h3);
    wr(A_STS, 32'hC);
    rd_check("R6 non-pending ones ignored", A_STS, 32'h3);
    wr(A_STS, 32'h2);
    rd_check("R6 only bit1 cleared", A_STS, 32'h1);
    check("R6 irq follows clear", {28'h0, irq}, 32'h1);
    wr(A_STS, 32'hF);
  endtask

  task automatic t_wrap;
    wr(A_IEN, 32'h4);
    wr(A_M2, 32'h5);
    wr(A_CNT, 32'hFFFF_FFFE);
    tick(6); idle(1);
    rd_check("R4 no early event across wrap", A_STS, 32'h0);
    tick(1);
    rd_check("R4 counter wrapped", A_CNT, 32'h5);
    rd_check("R4 event after wrap", A_STS, 32'h4);
    wr(A_STS, 32'hF);
  endtask

  task automatic t_load_no_match;
    wr(A_IEN, 32'h1);
    wr(A_M0, 32'h700);
    wr(A_CNT, 32'h700);
    idle(2);
    rd_check("R11 load equal to match no event", A_STS, 32'h0);
  endtask

  task automatic t_ien_width;
    wr(A_IEN, 32'hFFFF_FFFF);
    rd_check("R7 ien keeps 12 bits", A_IEN, 32'h0000_0FFF);
    wr(A_IEN, 32'h0);
  endtask

  task automatic t_wdog;
    int p0;
    logic [31:0] d; logic e;
    wr(A_STS, 32'hF);
    wr(A_WDG, 32'h1);
    wr(A_M3, 32'h900);
    wr(A_CNT, 32'h8FF);
    p0 = pulses;
    tick(1);
    idle(1);
    check("R8 reset request high", {31'h0, rst_req}, 32'h1);
    rd(A_WDG, d, e);
    check("R8 watchdog disarmed", d, 32'h0);
    check("R8 single-cycle pulse", 32'(pulses - p0), 32'd1);
    rd_check("R8 no status with ien clear", A_STS, 32'h0);
    p0 = pulses;
    wr(A_CNT, 32'h8FF);
    tick(1); idle(3);
    check("R8 no second shot once disarmed", 32'(pulses - p0), 32'd0);
    wr(A_WDG, 32'h2);
    wr(A_CNT, 32'h8FF);
    tick(1); idle(3);
    check("R8 bit0 clear no request", 32'(pulses - p0), 32'd0);
    rd_check("R8 register untouched", A_WDG, 32'h2);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    rd(8'h20, d, e);
    check("R9 unmapped data", d, 32'h0);
    check("R9 unmapped err", {31'h0, e}, 32'h1);
    rd(8'h06, d, e);
    check("R9 misaligned err", {31'h0, e}, 32'h1);
    rd(A_STS, d, e);
    check("R9 mapped no err", {31'h0, e}, 32'h0);
  endtask

  task automatic t_map;
    for (int i = 0; i < 4; i++) wr(8'(i * 4), 32'h1111_1111 * (i + 1));
    for (int i = 0; i < 4; i++)
      rd_check("R10 match offset", 8'(i * 4), 32'h1111_1111 * (i + 1));
    wr(A_IEN, 32'h0A5);
    rd_check("R10 ien offset", A_IEN, 32'h0A5);
    wr(A_WDG, 32'hABCD_0000);
    rd_check("R10 wdog offset", A_WDG, 32'hABCD_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_load();
    t_match_enabled();
    t_match_disabled();
    t_clear_mask();
    t_wrap();
    t_load_no_match();
    t_ien_width();
    t_wdog();
    t_unmapped();
    t_map();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule